// File: doc/BRIEF.md
# Bit-Field Extract/Insert Unit

This unit works on one 16-bit word at a time. An 8-bit field descriptor sits in a small control register and selects a contiguous field inside the word. The high nibble of the descriptor gives the position of the field's first bit. The low nibble gives the field length minus one. Bit positions are counted from the most significant end, so position 0 is operand bit 15.

Each request picks one of three operations, or a reserved code:

- **Extract** pulls the field out and right-justifies it.
- **Deposit** takes a right-justified value and moves it into field position, with every other bit zero.
- **Clear** zeroes the field bits of a word so that a positioned value can later be ORed into it.

All three operations share one circular left rotator and one mask generator. The result, an error flag and a valid strobe are registered and appear one cycle after the request. The error flag is raised when a descriptor's field runs past bit position 15.

Top module: `bitfield_unit`

## Requirements
- R1: After reset, valid_o, err_o and result_o are all 0, and the descriptor register holds 8'h00 (start 0, length 1).
- R2: When desc_load_i is high at a rising clock edge, desc_i is captured. A request in that same cycle still uses the previous descriptor, and the new one applies from the next cycle. desc[7:4] is the start position s and desc[3:0] is the length minus one, so L = desc[3:0]+1. Position p refers to operand bit 15-p.
- R3: valid_o is high in the cycle after each cycle in which req_i is high, and low otherwise.
- R4: op_i = 2'b00 (extract): result_o holds the L field bits right-justified, with all higher bits zero. That is, result = (operand >> (16-s-L)) & (2^L-1).
- R5: op_i = 2'b01 (deposit): result = (operand & (2^L-1)) << (16-s-L), with every bit outside the field zero.
- R6: op_i = 2'b10 (clear): result equals the operand with the field bits forced to zero and all other bits unchanged.
- R7: op_i = 2'b11 (reserved): result_o is 16'h0000.
- R8: With length 16 (descriptor 8'h0F), extract and deposit both return the operand unchanged, and clear returns zero.
- R9: err_o is high together with valid_o exactly when s+L-1 > 15, whatever the opcode; err_o is low whenever valid_o is low. The result is undefined for such descriptors, except under R7.
- R10: In a cycle that follows no request, result_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_load_i | input | 1 | Write strobe for the descriptor register |
| desc_i | input | 8 | New descriptor: start position in the high nibble, length minus one in the low nibble |
| req_i | input | 1 | Operation request |
| op_i | input | 2 | 00 extract, 01 deposit, 10 clear, 11 reserved |
| operand_i | input | 16 | Word to be operated on |
| result_o | output | 16 | Registered result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| err_o | output | 1 | Descriptor field runs past bit 15; qualified by valid_o |

## Verification
A wrong rotate amount or a wrong mask bound shows up at the ports on the very next cycle as a result word that is shifted or trimmed wrongly. The sweep covers every descriptor, so an off-by-one at the edges (length 16, start 15, end exactly 15) cannot hide. A descriptor register that updates too early or too late is exposed by a request issued in the same cycle as a load. A stuck strobe or a result register that changes without a request is caught by the idle cycle checked after every operation.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;
  typedef enum logic [1:0] {
    OP_EXTRACT = 2'b00,
    OP_DEPOSIT = 2'b01,
    OP_CLEAR   = 2'b10,
    OP_RSVD    = 2'b11
  } bf_op_e;
endpackage

// File: rtl/bf_desc_decode.sv
// Splits the descriptor into length and the two rotate amounts; W must be a power of two.
module bf_desc_decode #(
  parameter int W = 16,
  localparam int IDXW = $clog2(W),
  localparam int DW = 2 * IDXW
) (
  input  logic [DW-1:0]   desc_i,
  output logic [IDXW:0]   len_o,
  output logic [IDXW-1:0] ext_amt_o,
  output logic [IDXW-1:0] dep_amt_o,
  output logic            bad_o
);
  logic [IDXW-1:0] start;
  logic [IDXW-1:0] len_m1;
  logic [IDXW:0]   end_pos;

  assign start   = desc_i[DW-1:IDXW];
  assign len_m1  = desc_i[IDXW-1:0];
  assign end_pos = {1'b0, start} + {1'b0, len_m1};
  assign len_o   = {1'b0, len_m1} + (IDXW+1)'(1);
  assign bad_o   = end_pos[IDXW];
  // start+len mod W
  assign ext_amt_o = end_pos[IDXW-1:0] + IDXW'(1);
  // W-start-len mod W == ~(start+len-1)
  assign dep_amt_o = ~end_pos[IDXW-1:0];
endmodule

// File: rtl/bf_mask_gen.sv
module bf_mask_gen #(
  parameter int W = 16,
  localparam int IDXW = $clog2(W)
) (
  input  logic [IDXW:0]   len_i,
  input  logic [IDXW-1:0] pos_i,
  output logic [W-1:0]    low_o,
  output logic [W-1:0]    field_o
);
  always_comb begin
    if (len_i[IDXW]) low_o = '1;
    else             low_o = (W'(1) << len_i[IDXW-1:0]) - W'(1);
  end

  assign field_o = low_o << pos_i;
endmodule

// File: rtl/bf_rotl.sv
module bf_rotl #(
  parameter int W = 16,
  localparam int IDXW = $clog2(W)
) (
  input  logic [W-1:0]    data_i,
  input  logic [IDXW-1:0] amt_i,
  output logic [W-1:0]    data_o
);
  logic [W-1:0] stage [IDXW+1];

  assign stage[0] = data_i;

  for (genvar s = 0; s < IDXW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amt_i[s] ? {stage[s][W-1-SH:0], stage[s][W-1:W-SH]} : stage[s];
  end

  assign data_o = stage[IDXW];
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bitfield_pkg::*;
#(
  parameter int W = 16,
  localparam int IDXW = $clog2(W),
  localparam int DW = 2 * IDXW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          desc_load_i,
  input  logic [DW-1:0] desc_i,
  input  logic          req_i,
  input  logic [1:0]    op_i,
  input  logic [W-1:0]  operand_i,
  output logic [W-1:0]  result_o,
  output logic          valid_o,
  output logic          err_o
);
  logic [DW-1:0]   desc_q;
  logic [IDXW:0]   len;
  logic [IDXW-1:0] ext_amt, dep_amt, rot_amt;
  logic            bad;
  logic [W-1:0]    low_mask, field_mask, rotated, res_d;
  bf_op_e          op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          desc_q <= '0;
    else if (desc_load_i) desc_q <= desc_i;
  end

  bf_desc_decode #(.W(W)) u_dec (
    .desc_i   (desc_q),
    .len_o    (len),
    .ext_amt_o(ext_amt),
    .dep_amt_o(dep_amt),
    .bad_o    (bad)
  );

  bf_mask_gen #(.W(W)) u_mask (
    .len_i  (len),
    .pos_i  (dep_amt),
    .low_o  (low_mask),
    .field_o(field_mask)
  );

  assign op      = bf_op_e'(op_i);
  assign rot_amt = (op == OP_EXTRACT) ? ext_amt : dep_amt;

  // one rotator shared by extract and deposit
  bf_rotl #(.W(W)) u_rot (
    .data_i(operand_i),
    .amt_i (rot_amt),
    .data_o(rotated)
  );

  always_comb begin
    unique case (op)
      OP_EXTRACT: res_d = rotated & low_mask;
      OP_DEPOSIT: res_d = rotated & field_mask;
      OP_CLEAR:   res_d = operand_i & ~field_mask;
      default:    res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= req_i;
      err_o   <= req_i & bad;
      if (req_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] operand_i,
  input logic [W-1:0] result_o,
  input logic         valid_o,
  input logic         err_o
);
  AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o); // R3
  AST_ERR_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(result_o)); // R10
  AST_CLEAR_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 2'b10) |=> ((result_o & ~$past(operand_i)) == '0)); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 2'b11) |=> (result_o == '0)); // R7
endmodule

bind bitfield_unit bitfield_unit_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .op_i     (op_i),
  .operand_i(operand_i),
  .result_o (result_o),
  .valid_o  (valid_o),
  .err_o    (err_o)
);

// File: tb/bitfield_unit_bench.sv
`timescale 1ns/1ps
module bitfield_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_load = 1'b0;
  logic [7:0]  desc = '0;
  logic        req = 1'b0;
  logic [1:0]  op = '0;
  logic [15:0] operand = '0;
  logic [15:0] result;
  logic        valid, err;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bitfield_unit u_bitfield_unit (
    .clk_i(clk), .rst_ni(rst_n), .desc_load_i(desc_load), .desc_i(desc),
    .req_i(req), .op_i(op), .operand_i(operand),
    .result_o(result), .valid_o(valid), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input int o, input int s, input int lm1, input logic [15:0] x);
    int          len = lm1 + 1;
    int          sh = 16 - s - len;
    logic [31:0] low = (32'h1 << len) - 32'h1;
    logic [31:0] t;
    case (o)
      0: t = ({16'h0, x} >> sh) & low;
      1: t = ({16'h0, x} & low) << sh;
      2: t = {16'h0, x} & ~(low << sh);
      default: t = '0;
    endcase
    return t[15:0];
  endfunction

  task automatic load_desc(input logic [7:0] d);
    @(negedge clk); desc_load = 1'b1; desc = d;
    @(negedge clk); desc_load = 1'b0;
  endtask

  // issue one op under descriptor d, check result, then check an idle cycle
  task automatic run_op(input logic [7:0] d, input int o, input logic [15:0] x);
    int s = int'(d[7:4]);
    int lm1 = int'(d[3:0]);
    bit bad = (s + lm1) > 15;
    logic [15:0] exp = model(o, s, lm1, x);
    logic [15:0] held;
    @(negedge clk); req = 1'b1; op = 2'(o); operand = x;
    @(negedge clk); req = 1'b0; operand = ~x;
    chk(valid === 1'b1, "R3", {31'h0, valid}, 32'h1);
    chk(err === bad, "R9", {31'h0, err}, {31'h0, bad});
    if (!bad || o == 3) begin
      case (o)
        0: chk(result === exp, "R4", {16'h0, result}, {16'h0, exp});
        1: chk(result === exp, "R5", {16'h0, result}, {16'h0, exp});
        2: chk(result === exp, "R6", {16'h0, result}, {16'h0, exp});
        default: chk(result === 16'h0, "R7", {16'h0, result}, 32'h0);
      endcase
    end
    if (d == 8'h0F && o < 3) begin
      logic [15:0] e8 = (o == 2) ? 16'h0 : x;
      chk(result === e8, "R8", {16'h0, result}, {16'h0, e8});
    end
    held = result;
    @(negedge clk);
    chk(valid === 1'b0 && err === 1'b0, "R3", {30'h0, valid, err}, 32'h0);
    chk(result === held, "R10", {16'h0, result}, {16'h0, held});
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] pats [4];
    #12;
    chk(valid === 1'b0 && err === 1'b0 && result === 16'h0, "R1", {14'h0, valid, err, result}, 32'h0);
    rst_n = 1'b1;
    // reset descriptor is start 0, length 1: extract returns operand bit 15
    run_op(8'h00, 0, 16'h8000);
    @(negedge clk);
    chk(result === 16'h0001, "R1", {16'h0, result}, 32'h1);

    for (int d = 0; d < 256; d++) begin
      load_desc(8'(d));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pats[0] = 16'hFFFF; pats[1] = 16'hA5C3; pats[2] = 16'h0001; pats[3] = lfsr;
      for (int o = 0; o < 4; o++)
        for (int p = 0; p < 4; p++)
          run_op(8'(d), o, pats[p]);
    end

    // R2: load and request in the same cycle -> old descriptor applies
    load_desc(8'h44);
    @(negedge clk); desc_load = 1'b1; desc = 8'h83; req = 1'b1; op = 2'b00; operand = 16'h0F0F;
    @(negedge clk); desc_load = 1'b0; req = 1'b0;
    chk(result === model(0, 4, 4, 16'h0F0F), "R2", {16'h0, result}, {16'h0, model(0, 4, 4, 16'h0F0F)});
    run_op(8'h83, 0, 16'h0F0F);
    chk(1'b1, "R2", 32'h0, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule